// File: doc/BRIEF.md
# Frame-transfer CCD gate sequencer

This block drives the digital clocking of a frame-transfer image sensor that has two image-area gates, a storage-area gate, a serial-register gate and an antiblooming gate. A single start request runs one complete frame. First it empties the image area into the clear drain and leaves the storage area alone. Next comes an exposure window whose length is programmable, and during it the antiblooming gate is pulsed in bursts. The exposed image is then shifted wholesale into storage. Last, storage is read out one line at a time: each line is loaded into the serial register and clocked out pixel by pixel.

Each transfer clock on a gate is one system-clock cycle high followed by one cycle low. Only one activity runs at any time. While a serial shift is in progress, side-band flags mark the pixel position as a dummy cell, a shielded dark-reference column or an active pixel, so that downstream video logic can use them. The exposure length is given in units of `INT_UNIT` system clocks and is captured when the start request is accepted. A length of zero goes straight from the clear to the transfer into storage.

Top module: `ft_ccd_timing`

## Requirements
- R1: In the cycle after an accepted start, clearing begins. Both image gates pulse `LINES` (244) times, high on even cycles of the phase and low on odd cycles. The storage gate stays low throughout.
- R2: `int_len_i` is captured on the accepted start. Exposure lasts `int_len_i * INT_UNIT` cycles. A captured value of 0 skips exposure, and the transfer into storage follows the clear at once.
- R3: Each `INT_UNIT`-cycle exposure unit opens with `AB_PULSES` antiblooming pulses, one cycle high and one cycle low each. The antiblooming gate is low outside exposure.
- R4: The transfer into storage gives `LINES` pulses on which both image gates and the storage gate rise and fall together.
- R5: Readout covers `LINES` lines. Each line starts with one storage-gate pulse, which loads the serial register. `SER_CYC` (339) serial-gate pulses follow. Image gates stay low during readout.
- R6: The dummy flag is high for serial pixel indices 0 to `DUMMY_PIX-1` (0–1), counted from 0 within the line. It covers both the high and the low cycle of each pixel.
- R7: The dark flag is high for pixel indices `DUMMY_PIX` to `DUMMY_PIX+DARK_PIX-1` (2–13).
- R8: The active flag is high for the next `ACTIVE_PIX` indices (14–337). The remaining buffer index (338) raises no flag.
- R9: Busy is high from the first clear cycle through the low cycle of the last serial pulse of the last line. A start request while busy is ignored.
- R10: The frame-done output is high for exactly the one cycle after the final serial cycle. Busy is low in that cycle, and a start request in that cycle is accepted.
- R11: While reset is held, every output is low.
- R12: The serial gate is never high together with the storage gate or with an image gate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Frame start request |
| int_len_i | input | INT_W | Exposure length in units of INT_UNIT cycles |
| img_gate_a_o | output | 1 | Image-area gate, first drive |
| img_gate_b_o | output | 1 | Image-area gate, second drive |
| store_gate_o | output | 1 | Storage-area gate |
| ser_gate_o | output | 1 | Serial-register gate |
| bloom_gate_o | output | 1 | Antiblooming gate |
| busy_o | output | 1 | Frame sequence in progress |
| dummy_o | output | 1 | Current serial pixel is a dummy cell |
| dark_o | output | 1 | Current serial pixel is a dark-reference column |
| active_o | output | 1 | Current serial pixel is an active pixel |
| frame_done_o | output | 1 | One-cycle pulse after the final serial cycle |

## Verification
The bench targets these corners:
- Phase boundaries, where an off-by-one in the clear or transfer count would add or drop a gate pulse and shift every later line by two cycles.
- A zero exposure length, where a design that enters exposure anyway would wait forever or insert a stray antiblooming burst.
- Start requests that arrive mid-frame, which a faulty design would answer by restarting the clear.
- A start request in the frame-done cycle itself, which a design with an extra dead state would lose.
- The flag edges at indices 1/2, 13/14 and the final buffer pixel, which a wrong comparison would misplace by one pixel.

// File: rtl/ccd_tg_pkg.sv
package ccd_tg_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_CLEAR = 3'd1,
    PH_INTEG = 3'd2,
    PH_XFER  = 3'd3,
    PH_LOAD  = 3'd4,
    PH_SHIFT = 3'd5
  } tg_phase_e;
endpackage

// File: rtl/ccd_tg_shutter.sv
module ccd_tg_shutter #(
  parameter int INT_UNIT  = 1024,
  parameter int AB_PULSES = 4,
  parameter int INT_W     = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [INT_W-1:0] len_i,
  output logic             bloom_o,
  output logic             done_o
);
  localparam int T_W = (INT_UNIT > 1) ? $clog2(INT_UNIT) : 1;
  localparam logic [T_W-1:0] T_LAST  = T_W'(INT_UNIT - 1);
  localparam logic [T_W-1:0] AB_SPAN = T_W'(2 * AB_PULSES);

  logic [T_W-1:0]   t_q;
  logic [INT_W-1:0] u_q;
  logic             unit_end;

  assign unit_end = (t_q == T_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t_q <= '0;
      u_q <= '0;
    end else if (!en_i) begin
      t_q <= '0;
      u_q <= '0;
    end else if (unit_end) begin
      t_q <= '0;
      u_q <= u_q + 1'b1;
    end else begin
      t_q <= t_q + 1'b1;
    end
  end

  assign bloom_o = en_i && (t_q < AB_SPAN) && !t_q[0];
  assign done_o  = en_i && unit_end && (u_q == len_i - 1'b1);

  assert_bloom_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bloom_o |=> !bloom_o);
  assert_bloom_unit_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && $past(unit_end)) |-> bloom_o);
endmodule

// File: rtl/ccd_tg_seq.sv
module ccd_tg_seq
  import ccd_tg_pkg::*;
#(
  parameter int LINES   = 244,
  parameter int SER_CYC = 339,
  parameter int INT_W   = 12,
  parameter int CNT_W   = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [INT_W-1:0] int_len_i,
  input  logic             integ_done_i,
  output tg_phase_e        phase_o,
  output logic             half_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic [INT_W-1:0] len_o,
  output logic             frame_done_o
);
  localparam int LINE_W = (LINES > 1) ? $clog2(LINES) : 1;
  localparam logic [CNT_W-1:0]  LAST_ROW  = CNT_W'(LINES - 1);
  localparam logic [CNT_W-1:0]  LAST_PIX  = CNT_W'(SER_CYC - 1);
  localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(LINES - 1);

  tg_phase_e         phase_q;
  logic              half_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [LINE_W-1:0] line_q;
  logic [INT_W-1:0]  len_q;
  logic              done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      half_q  <= 1'b0;
      cnt_q   <= '0;
      line_q  <= '0;
      len_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q <= PH_CLEAR;
          half_q  <= 1'b0;
          cnt_q   <= '0;
          len_q   <= int_len_i;
        end
        PH_CLEAR: begin
          half_q <= ~half_q;
          if (half_q) begin
            if (cnt_q == LAST_ROW) begin
              cnt_q   <= '0;
              phase_q <= (len_q == '0) ? PH_XFER : PH_INTEG;
            end else cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_INTEG: if (integ_done_i) begin
          phase_q <= PH_XFER;
          cnt_q   <= '0;
        end
        PH_XFER: begin
          half_q <= ~half_q;
          if (half_q) begin
            if (cnt_q == LAST_ROW) begin
              cnt_q   <= '0;
              line_q  <= '0;
              phase_q <= PH_LOAD;
            end else cnt_q <= cnt_q + 1'b1;
          end
        end
        PH_LOAD: begin
          half_q <= ~half_q;
          if (half_q) begin
            cnt_q   <= '0;
            phase_q <= PH_SHIFT;
          end
        end
        PH_SHIFT: begin
          half_q <= ~half_q;
          if (half_q) begin
            if (cnt_q == LAST_PIX) begin
              cnt_q <= '0;
              if (line_q == LAST_LINE) begin
                phase_q <= PH_IDLE;
                done_q  <= 1'b1;
              end else begin
                line_q  <= line_q + 1'b1;
                phase_q <= PH_LOAD;
              end
            end else cnt_q <= cnt_q + 1'b1;
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o      = phase_q;
  assign half_o       = half_q;
  assign cnt_o        = cnt_q;
  assign len_o        = len_q;
  assign frame_done_o = done_q;

  // a new clear may only be entered from idle
  assert_clear_from_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_CLEAR && $past(phase_q) != PH_CLEAR) |-> $past(phase_q) == PH_IDLE);
  assert_done_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  assert_done_after_shift_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> ($past(phase_q) == PH_SHIFT && phase_q == PH_IDLE));
  assert_len_zero_skip_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_INTEG) |-> len_q != '0);
endmodule

// File: rtl/ccd_tg_drive.sv
module ccd_tg_drive
  import ccd_tg_pkg::*;
#(
  parameter int DUMMY_PIX  = 2,
  parameter int DARK_PIX   = 12,
  parameter int ACTIVE_PIX = 324,
  parameter int CNT_W      = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  tg_phase_e        phase_i,
  input  logic             half_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic             img_gate_a_o,
  output logic             img_gate_b_o,
  output logic             store_gate_o,
  output logic             ser_gate_o,
  output logic             busy_o,
  output logic             dummy_o,
  output logic             dark_o,
  output logic             active_o
);
  localparam logic [CNT_W-1:0] DARK_LO   = CNT_W'(DUMMY_PIX);
  localparam logic [CNT_W-1:0] ACTIVE_LO = CNT_W'(DUMMY_PIX + DARK_PIX);
  localparam logic [CNT_W-1:0] BUF_LO    = CNT_W'(DUMMY_PIX + DARK_PIX + ACTIVE_PIX);

  logic shifting;
  assign shifting = (phase_i == PH_SHIFT);

  assign img_gate_a_o = (phase_i == PH_CLEAR || phase_i == PH_XFER) && !half_i;
  assign img_gate_b_o = img_gate_a_o;
  assign store_gate_o = (phase_i == PH_XFER || phase_i == PH_LOAD) && !half_i;
  assign ser_gate_o   = shifting && !half_i;
  assign busy_o       = (phase_i != PH_IDLE);

  assign dummy_o  = shifting && (cnt_i < DARK_LO);
  assign dark_o   = shifting && (cnt_i >= DARK_LO) && (cnt_i < ACTIVE_LO);
  assign active_o = shifting && (cnt_i >= ACTIVE_LO) && (cnt_i < BUF_LO);

  assert_ser_exclusive_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_gate_o |-> !(store_gate_o || img_gate_a_o || img_gate_b_o));
  assert_flags_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dummy_o, dark_o, active_o}));
  assert_ser_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_gate_o |=> !ser_gate_o);
  assert_store_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    store_gate_o |=> !store_gate_o);
  assert_flag_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dummy_o || dark_o || active_o) |-> busy_o);
endmodule

// File: rtl/ft_ccd_timing.sv
module ft_ccd_timing
  import ccd_tg_pkg::*;
#(
  parameter int LINES      = 244,
  parameter int SER_CYC    = 339,
  parameter int DUMMY_PIX  = 2,
  parameter int DARK_PIX   = 12,
  parameter int ACTIVE_PIX = 324,
  parameter int INT_UNIT   = 1024,
  parameter int AB_PULSES  = 4,
  parameter int INT_W      = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [INT_W-1:0] int_len_i,
  output logic             img_gate_a_o,
  output logic             img_gate_b_o,
  output logic             store_gate_o,
  output logic             ser_gate_o,
  output logic             bloom_gate_o,
  output logic             busy_o,
  output logic             dummy_o,
  output logic             dark_o,
  output logic             active_o,
  output logic             frame_done_o
);
  localparam int CNT_MAX = (LINES > SER_CYC) ? LINES : SER_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  tg_phase_e        phase;
  logic             half;
  logic [CNT_W-1:0] cnt;
  logic [INT_W-1:0] len;
  logic             integ_done;

  ccd_tg_seq #(
    .LINES(LINES), .SER_CYC(SER_CYC), .INT_W(INT_W), .CNT_W(CNT_W)
  ) u_seq (
    .clk_i, .rst_ni, .start_i, .int_len_i,
    .integ_done_i (integ_done),
    .phase_o      (phase),
    .half_o       (half),
    .cnt_o        (cnt),
    .len_o        (len),
    .frame_done_o (frame_done_o)
  );

  ccd_tg_shutter #(
    .INT_UNIT(INT_UNIT), .AB_PULSES(AB_PULSES), .INT_W(INT_W)
  ) u_shutter (
    .clk_i, .rst_ni,
    .en_i    (phase == PH_INTEG),
    .len_i   (len),
    .bloom_o (bloom_gate_o),
    .done_o  (integ_done)
  );

  ccd_tg_drive #(
    .DUMMY_PIX(DUMMY_PIX), .DARK_PIX(DARK_PIX), .ACTIVE_PIX(ACTIVE_PIX), .CNT_W(CNT_W)
  ) u_drive (
    .clk_i, .rst_ni,
    .phase_i      (phase),
    .half_i       (half),
    .cnt_i        (cnt),
    .img_gate_a_o, .img_gate_b_o, .store_gate_o, .ser_gate_o,
    .busy_o, .dummy_o, .dark_o, .active_o
  );

  assert_busy_covers_gates_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (img_gate_a_o || store_gate_o || ser_gate_o || bloom_gate_o) |-> busy_o);
  assert_done_not_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> !busy_o);
  assert_clear_no_store_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (img_gate_a_o && !store_gate_o) |-> $past(busy_o) || $past(start_i) || !$past(store_gate_o));
endmodule

// File: tb/ft_ccd_timing_bench.sv
module ft_ccd_timing_bench;
  localparam int CLK_PERIOD = 10;
  localparam int L  = 6;
  localparam int S  = 20;
  localparam int D  = 2;
  localparam int K  = 3;
  localparam int A  = 14;
  localparam int U  = 16;
  localparam int AB = 3;
  localparam int IW = 4;
  localparam int P  = 2 + 2 * S;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [IW-1:0] int_len = '0;
  logic iga, igb, sg, srg, abg, busy, dmy, drk, act, done;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  ft_ccd_timing #(
    .LINES(L), .SER_CYC(S), .DUMMY_PIX(D), .DARK_PIX(K), .ACTIVE_PIX(A),
    .INT_UNIT(U), .AB_PULSES(AB), .INT_W(IW)
  ) u_ft_ccd_timing (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .int_len_i(int_len),
    .img_gate_a_o(iga), .img_gate_b_o(igb), .store_gate_o(sg), .ser_gate_o(srg),
    .bloom_gate_o(abg), .busy_o(busy), .dummy_o(dmy), .dark_o(drk), .active_o(act),
    .frame_done_o(done)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // reference model: time offset since accepted start
  bit m_busy = 1'b0;
  bit m_done = 1'b0;
  int m_t = 0;
  int m_len = 0;

  function automatic int frame_end(int len);
    return 4 * L + len * U + L * P;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 1'b0; m_done <= 1'b0; m_t <= 0; m_len <= 0;
    end else begin
      m_done <= 1'b0;
      if (m_busy) begin
        if (m_t == frame_end(m_len) - 1) begin
          m_busy <= 1'b0;
          m_done <= 1'b1;
        end else m_t <= m_t + 1;
      end else if (start) begin
        m_busy <= 1'b1;
        m_t    <= 0;
        m_len  <= int'(int_len);
      end
    end
  end

  task automatic chk(input logic act_v, input bit exp_v, input string tag, input string nm);
    checks++;
    if (act_v !== exp_v) begin
      failures++;
      $display("FAIL %s %s at t=%0d: actual=%b expected=%b", tag, nm, m_t, act_v, exp_v);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      bit e_ig, e_sg, e_srg, e_abg, e_dmy, e_drk, e_act;
      int c0, ie, xe, k, p;
      e_ig = 0; e_sg = 0; e_srg = 0; e_abg = 0; e_dmy = 0; e_drk = 0; e_act = 0;
      c0 = 2 * L; ie = c0 + m_len * U; xe = ie + 2 * L;
      if (m_busy) begin
        if (m_t < c0) e_ig = (m_t % 2 == 0);
        else if (m_t < ie) begin
          k = (m_t - c0) % U;
          e_abg = (k < 2 * AB) && (k % 2 == 0);
        end else if (m_t < xe) begin
          e_ig = ((m_t - ie) % 2 == 0);
          e_sg = e_ig;
        end else begin
          k = (m_t - xe) % P;
          if (k < 2) e_sg = (k == 0);
          else begin
            p = (k - 2) / 2;
            e_srg = (k % 2 == 0);
            e_dmy = (p < D);
            e_drk = (p >= D) && (p < D + K);
            e_act = (p >= D + K) && (p < D + K + A);
          end
        end
      end
      chk(iga, e_ig, "R1", "image gate a");
      chk(igb, e_ig, "R4", "image gate b");
      chk(sg, e_sg, "R5", "storage gate");
      chk(srg, e_srg, "R12", "serial gate");
      chk(abg, e_abg, "R3", "antiblooming gate");
      chk(dmy, e_dmy, "R6", "dummy flag");
      chk(drk, e_drk, "R7", "dark flag");
      chk(act, e_act, "R8", "active flag");
      chk(busy, m_busy, "R9", "busy");
      chk(done, m_done, "R10", "frame done");
    end
  end

  task automatic pulse_start(input int len);
    @(negedge clk);
    int_len = IW'(len);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: outputs low during reset
    chk(iga | igb | sg | srg | abg, 1'b0, "R11", "gates in reset");
    chk(busy | dmy | drk | act | done, 1'b0, "R11", "status in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2: two-unit exposure; R9: starts mid-frame are ignored
    pulse_start(2);
    repeat (5) @(negedge clk);
    start = 1'b1; int_len = 4'd7;
    repeat (3) @(negedge clk);
    start = 1'b0;
    repeat (150) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done();

    // R10: start held in the done cycle is accepted; R2: zero length skips exposure
    int_len = 4'd0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    wait_done();

    repeat (4) @(negedge clk);
    pulse_start(1);
    wait_done();
    repeat (6) @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      failures++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule